// File: doc/BRIEF.md
# Serial Gain Word Receiver Latch

This block is the digital control front end of a programmable gain stage. A host writes an 8-bit gain code over a three-wire serial link: a serial clock, a data line and an active-low load line. The block samples all three pins with its own fast system clock. Each pin passes through a synchroniser before its edges are detected. The system clock must run at least four times faster than the serial clock.

While the load line is low, bits enter a shift register, most significant bit first. The gain output keeps its old value during this time. Each bit is taken in two steps. A rising serial clock captures it into a master stage. The following falling edge moves it into the shift register.

When the load line rises, the shift register is copied to the gain output and a one-cycle update strobe fires. Shifting then stops until the load line falls again. If the word did not contain exactly eight bits, a count error flag is raised. The shift register still holds the last eight bits received.

An active-low power-down input clears the output-enable flag at once and without waiting for a clock. The gain code survives power-down. A new word can be loaded while the block is powered down, so the gain can be preset before the output comes back.

Top module: `gain_word_rx`

## Requirements
- R1: After a load of exactly 8 bits, `gain_o` equals those bits with the first bit sent in bit 7 and the last bit sent in bit 0.
- R2: A bit's value is taken at the rising serial clock edge. A change of the data line between that rising edge and the next falling edge does not change the stored bit.
- R3: While the load line is low, `gain_o` keeps its previous value and `upd_o` stays low, whatever bits are being shifted.
- R4: A rising load line copies the shift register to `gain_o`. On the same clock edge, `upd_o` goes high for exactly one cycle.
- R5: While the load line is high, serial clock and data activity does not change the shift register. A later load with no bits latches the unchanged contents.
- R6: When `pd_n_i` is low, `out_en_o` is low with no clock edge needed, and `gain_o` keeps its value.
- R7: Words shift in and latch normally while `pd_n_i` is low. `out_en_o` rises as soon as `pd_n_i` returns high.
- R8: While `rst_n` is low and the load line is low, `gain_o` is 0 and `upd_o`, `cnt_err_o` and `out_en_o` are 0. `out_en_o` is 1 from the first clock edge after reset is released, provided `pd_n_i` is high.
- R9: At each update, `cnt_err_o` becomes 1 if the number of bits shifted since the load line fell was not 8, and 0 otherwise. If more than 8 bits were shifted, `gain_o` gets the last 8 received.
- R10: If a falling serial clock edge reaches the block in the same system cycle as the rising load edge, that bit is not shifted and not counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ser_clk_i | input | 1 | Serial clock pin (asynchronous) |
| ser_data_i | input | 1 | Serial data pin (asynchronous) |
| load_n_i | input | 1 | Load line: low = shift, rising = latch |
| pd_n_i | input | 1 | Power-down, active low, asynchronous |
| gain_o | output | 8 | Active gain code |
| out_en_o | output | 1 | Output enable flag |
| upd_o | output | 1 | One-cycle strobe when the gain latch loads |
| cnt_err_o | output | 1 | Bit count of the last loaded word was not 8 |

## Verification
Two things can happen in the same system cycle: the last falling serial clock edge that would shift a bit, and the rising load edge that freezes the register and latches it. Both pins pass through identical synchronisers. The bench therefore drives the falling clock and the rising load line in the same system cycle, so both edges are seen together. The test loads seven ones after a known word and makes the eighth bit a zero whose falling edge meets the load edge. The result is judged on `gain_o` and `cnt_err_o`. A dropped bit gives 0x7F with the error flag set. A bit that was wrongly accepted gives 0xFE with the flag clear.

// File: rtl/gwr_pkg.sv
package gwr_pkg;
   localparam int unsigned GWR_MIN_SYNC = 2;

   function automatic int unsigned gwr_cnt_bits(input int unsigned word_w);
      return $clog2(word_w + 2);
   endfunction
endpackage

// File: rtl/gwr_sync.sv
module gwr_sync #(
   parameter int unsigned WIDTH   = 1,
   parameter int unsigned STAGES  = 2,
   parameter logic [WIDTH-1:0] RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] async_i,
   output logic [WIDTH-1:0] sync_o
);
   if (STAGES < gwr_pkg::GWR_MIN_SYNC) begin : g_bad_stages
      $error("gwr_sync: STAGES below minimum");
   end

   logic [WIDTH-1:0] chain_q [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk) begin
         if (!rst_n)       chain_q[s] <= RST_VAL;
         else if (s == 0)  chain_q[s] <= async_i;
         else              chain_q[s] <= chain_q[(s == 0) ? 0 : s-1];
      end
   end

   assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/gwr_edge.sv
module gwr_edge #(
   parameter logic RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic lvl_i,
   output logic rise_o,
   output logic fall_o
);
   logic prev_q;

   always_ff @(posedge clk) begin
      if (!rst_n) prev_q <= RST_VAL;
      else        prev_q <= lvl_i;
   end

   assign rise_o = lvl_i & ~prev_q;
   assign fall_o = ~lvl_i & prev_q;
endmodule

// File: rtl/gwr_shift.sv
module gwr_shift #(
   parameter int unsigned WORD_W    = 8,
   parameter bit          MSB_FIRST = 1'b1,
   localparam int unsigned CNT_W    = gwr_pkg::gwr_cnt_bits(WORD_W)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              shift_en_i,
   input  logic              clr_i,
   input  logic              sclk_rise_i,
   input  logic              sclk_fall_i,
   input  logic              sdat_i,
   output logic [WORD_W-1:0] sr_o,
   output logic [CNT_W-1:0]  cnt_o
);
   localparam logic [CNT_W-1:0] CNT_SAT = CNT_W'(WORD_W + 1);

   logic              master_q;
   logic [WORD_W-1:0] sr_q, sr_nxt;
   logic [CNT_W-1:0]  cnt_q, cnt_nxt;
   logic              do_shift;

   assign do_shift = shift_en_i & sclk_fall_i;

   if (MSB_FIRST) begin : g_msb
      if (WORD_W > 1) begin : g_wide
         assign sr_nxt = {sr_q[WORD_W-2:0], master_q};
      end else begin : g_one
         assign sr_nxt = master_q;
      end
   end else begin : g_lsb
      if (WORD_W > 1) begin : g_wide
         assign sr_nxt = {master_q, sr_q[WORD_W-1:1]};
      end else begin : g_one
         assign sr_nxt = master_q;
      end
   end

   always_comb begin
      cnt_nxt = clr_i ? '0 : cnt_q;
      if (do_shift && cnt_nxt != CNT_SAT) cnt_nxt = cnt_nxt + 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         master_q <= 1'b0;
         sr_q     <= '0;
         cnt_q    <= '0;
      end else begin
         if (shift_en_i && sclk_rise_i) master_q <= sdat_i;
         if (do_shift)                  sr_q     <= sr_nxt;
         cnt_q <= cnt_nxt;
      end
   end

   assign sr_o  = sr_q;
   assign cnt_o = cnt_q;
endmodule

// File: rtl/gwr_latch.sv
module gwr_latch #(
   parameter int unsigned WORD_W = 8,
   localparam int unsigned CNT_W = gwr_pkg::gwr_cnt_bits(WORD_W)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              take_i,
   input  logic [WORD_W-1:0] sr_i,
   input  logic [CNT_W-1:0]  cnt_i,
   output logic [WORD_W-1:0] gain_o,
   output logic              upd_o,
   output logic              err_o
);
   localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(WORD_W);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         gain_o <= '0;
         upd_o  <= 1'b0;
         err_o  <= 1'b0;
      end else begin
         upd_o <= take_i;
         if (take_i) begin
            gain_o <= sr_i;
            err_o  <= (cnt_i != CNT_FULL);
         end
      end
   end
endmodule

// File: rtl/gain_word_rx.sv
module gain_word_rx #(
   parameter int unsigned WORD_W      = 8,
   parameter int unsigned SYNC_STAGES = 2,
   parameter bit          MSB_FIRST   = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ser_clk_i,
   input  logic              ser_data_i,
   input  logic              load_n_i,
   input  logic              pd_n_i,
   output logic [WORD_W-1:0] gain_o,
   output logic              out_en_o,
   output logic              upd_o,
   output logic              cnt_err_o
);
   localparam int unsigned CNT_W = gwr_pkg::gwr_cnt_bits(WORD_W);

   if (WORD_W < 1) begin : g_bad_width
      $error("gain_word_rx: WORD_W must be at least 1");
   end

   // pin order in the synchronised vector: {load, data, sclk}
   logic [2:0]        pins_s;
   logic              sclk_lvl, sdat_lvl, load_lvl;
   logic              sclk_rise, sclk_fall, load_rise, load_fall;
   logic [WORD_W-1:0] sr_q;
   logic [CNT_W-1:0]  cnt_q;
   logic              run_q;

   gwr_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
      .clk(clk), .rst_n(rst_n),
      .async_i({load_n_i, ser_data_i, ser_clk_i}),
      .sync_o(pins_s)
   );

   assign sclk_lvl = pins_s[0];
   assign sdat_lvl = pins_s[1];
   assign load_lvl = pins_s[2];

   gwr_edge #(.RST_VAL(1'b0)) u_sclk_edge (
      .clk(clk), .rst_n(rst_n), .lvl_i(sclk_lvl),
      .rise_o(sclk_rise), .fall_o(sclk_fall)
   );

   gwr_edge #(.RST_VAL(1'b1)) u_load_edge (
      .clk(clk), .rst_n(rst_n), .lvl_i(load_lvl),
      .rise_o(load_rise), .fall_o(load_fall)
   );

   gwr_shift #(.WORD_W(WORD_W), .MSB_FIRST(MSB_FIRST)) u_shift (
      .clk(clk), .rst_n(rst_n),
      .shift_en_i(~load_lvl), .clr_i(load_fall),
      .sclk_rise_i(sclk_rise), .sclk_fall_i(sclk_fall),
      .sdat_i(sdat_lvl), .sr_o(sr_q), .cnt_o(cnt_q)
   );

   gwr_latch #(.WORD_W(WORD_W)) u_latch (
      .clk(clk), .rst_n(rst_n), .take_i(load_rise),
      .sr_i(sr_q), .cnt_i(cnt_q),
      .gain_o(gain_o), .upd_o(upd_o), .err_o(cnt_err_o)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) run_q <= 1'b0;
      else        run_q <= 1'b1;
   end

   // power-down gates the flag with no clock in the path
   assign out_en_o = pd_n_i & run_q;
endmodule

// File: rtl/gwr_chk.sv
module gwr_chk #(
   parameter int unsigned WORD_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              pd_n_i,
   input logic [WORD_W-1:0] gain_o,
   input logic              out_en_o,
   input logic              upd_o,
   input logic              cnt_err_o,
   input logic              load_lvl,
   input logic [WORD_W-1:0] sr_q
);
   // R3 / R4: gain moves only together with the strobe
   p_gain_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(gain_o) |-> upd_o);

   // R4: the strobe lasts a single cycle
   p_strobe_one_r4: assert property (@(posedge clk) disable iff (!rst_n)
      upd_o |=> !upd_o);

   // R5: shift register frozen while the load line is high
   p_freeze_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $past(load_lvl) |-> $stable(sr_q));

   // R9: error flag changes only on an update
   p_err_on_upd_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(cnt_err_o) |-> upd_o);

   // R6: power-down forces the enable flag low at once
   always_comb begin
      if (pd_n_i == 1'b0) begin
         a_pd_gate_r6: assert (out_en_o == 1'b0);
      end
   end
endmodule

bind gain_word_rx gwr_chk #(.WORD_W(WORD_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .pd_n_i(pd_n_i),
   .gain_o(gain_o), .out_en_o(out_en_o), .upd_o(upd_o),
   .cnt_err_o(cnt_err_o), .load_lvl(load_lvl), .sr_q(sr_q)
);

// File: tb/tb_gain_word_rx.sv
module tb_gain_word_rx;
   logic       clk = 1'b0;
   logic       rst_n, sclk, sdat, load_n, pd_n;
   logic [7:0] gain;
   logic       out_en, upd, err;
   int         total = 0, bad = 0, upd_cnt = 0;
   bit         done = 1'b0;

   always #2.5 clk = ~clk;

   gain_word_rx dut (
      .clk(clk), .rst_n(rst_n), .ser_clk_i(sclk), .ser_data_i(sdat),
      .load_n_i(load_n), .pd_n_i(pd_n), .gain_o(gain),
      .out_en_o(out_en), .upd_o(upd), .cnt_err_o(err)
   );

   always @(negedge clk) if (upd === 1'b1) upd_cnt++;

   // [31:16] bit stream, [15:12] bit count, [8] expected error, [7:0] expected gain
   localparam logic [31:0] VEC [7] = '{
      32'h00A5_80A5, 32'h003C_803C, 32'h00FF_80FF, 32'h0000_8000,
      32'h0005_3105, 32'h02D3_A1D3, 32'h0080_8080
   };

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic send_bit(input logic b, input bit glitch);
      sdat = b;  tick(4);
      sclk = 1'b1; tick(4);
      if (glitch) sdat = ~b;
      sclk = 1'b0; tick(4);
   endtask

   task automatic frame(input logic [15:0] s, input int n, input bit glitch);
      load_n = 1'b0; tick(4);
      for (int i = n - 1; i >= 0; i--) send_bit(s[i], glitch);
      load_n = 1'b1; tick(8);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      int u0;
      rst_n = 1'b0; sclk = 1'b0; sdat = 1'b0; load_n = 1'b0; pd_n = 1'b1;
      tick(5);
      chk(gain == 8'h00 && upd == 1'b0 && err == 1'b0, "R8 reset outputs", {gain, upd, err}, 0);
      chk(out_en == 1'b0, "R8 enable in reset", out_en, 0);
      rst_n = 1'b1; tick(1);
      chk(out_en == 1'b1, "R8 enable after reset", out_en, 1);

      // R1 / R4 / R9 vector walk
      for (int v = 0; v < 7; v++) begin
         u0 = upd_cnt;
         frame(VEC[v][31:16], int'(VEC[v][15:12]), 1'b0);
         chk(gain == VEC[v][7:0], "R1 R9 gain", gain, VEC[v][7:0]);
         chk(err == VEC[v][8], "R9 count flag", err, VEC[v][8]);
         chk(upd_cnt - u0 == 1, "R4 one strobe", upd_cnt - u0, 1);
      end

      // R2: data flips between rising and falling clock
      frame(16'h0069, 8, 1'b1);
      chk(gain == 8'h69, "R2 master capture", gain, 8'h69);

      // R3: gain holds during a partial load
      u0 = upd_cnt;
      load_n = 1'b0; tick(4);
      send_bit(1, 0); send_bit(0, 0); send_bit(1, 0); send_bit(0, 0);
      chk(gain == 8'h69 && upd_cnt == u0, "R3 hold while loading", gain, 8'h69);
      send_bit(0, 0); send_bit(1, 0); send_bit(1, 0); send_bit(0, 0);
      load_n = 1'b1; tick(8);
      chk(gain == 8'hA6 && err == 1'b0, "R3 word after hold", gain, 8'hA6);

      // R5: activity with load high, then an empty load
      for (int k = 0; k < 5; k++) send_bit(1, 0);
      load_n = 1'b0; tick(6); load_n = 1'b1; tick(8);
      chk(gain == 8'hA6, "R5 register frozen", gain, 8'hA6);
      chk(err == 1'b1, "R5 empty load flagged", err, 1);

      // R6: power-down gates the enable without a clock
      #1 pd_n = 1'b0; #0.5;
      chk(out_en == 1'b0, "R6 immediate disable", out_en, 0);
      chk(gain == 8'hA6, "R6 gain kept", gain, 8'hA6);

      // R7: preset during power-down
      tick(1);
      frame(16'h0042, 8, 1'b0);
      chk(gain == 8'h42 && err == 1'b0, "R7 load in power-down", gain, 8'h42);
      chk(out_en == 1'b0, "R7 still disabled", out_en, 0);
      #1 pd_n = 1'b1; #0.5;
      chk(out_en == 1'b1, "R7 enable returns", out_en, 1);
      tick(1);

      // R10: last falling clock meets the rising load line
      load_n = 1'b0; tick(4);
      for (int k = 0; k < 7; k++) send_bit(1, 0);
      sdat = 1'b0; tick(4);
      sclk = 1'b1; tick(4);
      sclk = 1'b0; load_n = 1'b1; tick(10);
      chk(gain == 8'h7F, "R10 coincident bit dropped", gain, 8'h7F);
      chk(err == 1'b1, "R10 bit not counted", err, 1);

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule